// File: doc/BRIEF.md
# Fast Interrupt Source Controller

This block looks after a single high-priority interrupt source and presents it to a processor as an active-low request line. The raw source signal is brought into the clock domain through a synchroniser. It is then qualified according to a programmable sensitivity: a rising edge, a falling edge, a high level or a low level. The qualified request is gated by an enable bit that software sets and clears through two separate write-one command addresses.

A register holds the address of the handler routine. Reading the fast vector location returns that address, so the processor can branch to the handler in a single load. When an edge sensitivity is selected, the same read also acknowledges the request: the latched edge is cleared and the request line goes high again. Under a level sensitivity the read acknowledges nothing. The line stays low until the source itself goes inactive.

Top module: `fast_irq_ctrl`

## Requirements
- R1: After reset, `fiq_req_n` is 1, and reads of the mask status, sensitivity and handler registers all return 0.
- R2: Sensitivity code 0 (rising edge, sensitivity register at offset 0x000, bits [1:0]) latches a request on a 0-to-1 transition of the synchronised source. A 1-to-0 transition latches nothing.
- R3: Sensitivity code 1 (falling edge) latches a request on a 1-to-0 transition of the synchronised source. A 0-to-1 transition latches nothing.
- R4: Sensitivity code 2 (high level) asserts the request exactly while the synchronised source is 1. A read of the fast vector location does not clear it.
- R5: Sensitivity code 3 (low level) asserts the request exactly while the synchronised source is 0. A read of the fast vector location does not clear it.
- R6: A write with data bit 0 set to the enable command address (0x120) enables the source, and such a write to the disable command address (0x124) disables it. Writes with bit 0 clear to either address change nothing.
- R7: Bit 0 of the mask status register (offset 0x110, read-only) reads 1 when the source is enabled and 0 when it is disabled.
- R8: The value written to the handler register (offset 0x080) is returned unchanged by reads of both offset 0x080 and the fast vector location (offset 0x104).
- R9: Under an edge sensitivity, a read of offset 0x104 clears the latched request, and `fiq_req_n` is 1 in the cycle after that read.
- R10: Disabling the source while an edge request is latched drives `fiq_req_n` high but keeps the latch. Enabling the source again drives the line low without a new edge.
- R11: When a qualifying edge is detected in the same cycle as a clearing read of offset 0x104, the request remains latched.
- R12: `bus_rdata` is updated in the cycle after `bus_re` is sampled and holds its value until the next read. A read of an unmapped offset returns 0.
- R13: `fiq_req_n` is 0 exactly when the source is enabled and a request is pending. The source is sampled through two flip-flops before it is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (12) | Byte offset within the block's window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W (32) | Registered read data |
| fiq_src | input | 1 | Asynchronous interrupt source |
| fiq_req_n | output | 1 | Active-low fast interrupt request to the processor |

## Verification
The source is driven with a rising step, a falling step, a held high level and a held low level. Each pattern is applied under a sensitivity that should accept it and under one that should ignore it, so a swapped polarity or an edge mistaken for a level shows up as a request line that is wrong at the sampled cycle. The vector read is issued both under edge sensitivity, where it must clear the request, and under level sensitivity, where it must not. A read is also timed to land in the same cycle as a fresh edge, which separates the correct "edge wins" priority from "clear wins". Disabling and re-enabling around a latched edge checks that the mask hides the request without discarding it.

// File: rtl/fiq_pkg.sv
package fiq_pkg;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  // Byte offsets inside the block's window
  localparam int unsigned OFF_SENSE  = 32'h000;
  localparam int unsigned OFF_HANDLR = 32'h080;
  localparam int unsigned OFF_FVEC   = 32'h104;
  localparam int unsigned OFF_MASK   = 32'h110;
  localparam int unsigned OFF_ENCMD  = 32'h120;
  localparam int unsigned OFF_DISCMD = 32'h124;

endpackage

// File: rtl/fiq_sync.sv
module fiq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fiq_detect.sv
module fiq_detect
  import fiq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   sample,
  input  logic   clr_req,
  output logic   pending
);

  logic prev_q, prev_d;
  logic latch_q, latch_d;
  logic rise, fall, edge_mode, hit;

  always_comb begin
    rise      = sample & ~prev_q;
    fall      = ~sample & prev_q;
    edge_mode = (mode == SENSE_RISE) || (mode == SENSE_FALL);
    hit       = ((mode == SENSE_RISE) && rise) || ((mode == SENSE_FALL) && fall);
    prev_d    = sample;
    latch_d   = latch_q;
    if (edge_mode && clr_req) latch_d = 1'b0;
    if (hit)                  latch_d = 1'b1;   // new edge beats the clear
    case (mode)
      SENSE_HIGH: pending = sample;
      SENSE_LOW:  pending = ~sample;
      default:    pending = latch_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      latch_q <= latch_d;
    end
  end

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr_req && !hit) |=> !latch_q);

  a_r11_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> latch_q);

  a_r4_level_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> $stable(latch_q));

endmodule

// File: rtl/fiq_regs.sv
module fiq_regs
  import fiq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output sense_e            mode,
  output logic              enabled,
  output logic              clr_req
);

  localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(OFF_SENSE);
  localparam logic [ADDR_W-1:0] A_HANDLR = ADDR_W'(OFF_HANDLR);
  localparam logic [ADDR_W-1:0] A_FVEC   = ADDR_W'(OFF_FVEC);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_ENCMD  = ADDR_W'(OFF_ENCMD);
  localparam logic [ADDR_W-1:0] A_DISCMD = ADDR_W'(OFF_DISCMD);

  sense_e            mode_q, mode_d;
  logic              en_q, en_d;
  logic [DATA_W-1:0] vec_q, vec_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              mapped;

  always_comb begin
    mode_d = mode_q;
    en_d   = en_q;
    vec_d  = vec_q;
    if (we) begin
      case (addr)
        A_SENSE:  mode_d = sense_e'(wdata[1:0]);
        A_HANDLR: vec_d  = wdata;
        A_ENCMD:  if (wdata[0]) en_d = 1'b1;
        A_DISCMD: if (wdata[0]) en_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    mapped = 1'b1;
    case (addr)
      A_SENSE:           rd_d = DATA_W'(mode_q);
      A_HANDLR, A_FVEC:  rd_d = vec_q;
      A_MASK:            rd_d = DATA_W'(en_q);
      default: begin
        rd_d   = '0;
        mapped = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SENSE_RISE;
      en_q   <= 1'b0;
      vec_q  <= '0;
      rd_q   <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      vec_q  <= vec_d;
      if (re) rd_q <= rd_d;
    end
  end

  assign rdata   = rd_q;
  assign mode    = mode_q;
  assign enabled = en_q;
  assign clr_req = re && (addr == A_FVEC);

  a_r6_enable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_ENCMD && wdata[0]) |=> enabled);

  a_r6_disable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DISCMD && wdata[0]) |=> !enabled);

  a_r6_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == A_ENCMD || addr == A_DISCMD) && !wdata[0]) |=> $stable(enabled));

  a_r8_vector_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == A_FVEC) |=> rdata == $past(vec_q));

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !mapped) |=> rdata == '0);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/fast_irq_ctrl.sv
module fast_irq_ctrl
  import fiq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fiq_src,
  output logic              fiq_req_n
);

  logic   rst_n_i;
  logic   src_s;
  logic   enabled, clr_req, pending;
  sense_e mode;

  // Reset asserts at once, releases after two clock edges
  fiq_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_i)
  );

  fiq_sync #(.STAGES(SYNC_STAGES)) u_src_sync (
    .clk(clk), .rst_n(rst_n_i), .d(fiq_src), .q(src_s)
  );

  fiq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .rdata(bus_rdata), .mode(mode),
    .enabled(enabled), .clr_req(clr_req)
  );

  fiq_detect u_detect (
    .clk(clk), .rst_n(rst_n_i), .mode(mode), .sample(src_s),
    .clr_req(clr_req), .pending(pending)
  );

  assign fiq_req_n = ~(enabled & pending);

  a_r13_masked_high: assert property (@(posedge clk) disable iff (!rst_n_i)
    !enabled |-> fiq_req_n);

  a_r10_disable_releases: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(enabled) |-> fiq_req_n);

endmodule

// File: tb/sim_fast_irq_ctrl.sv
module sim_fast_irq_ctrl;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_SENSE = 12'h000, A_HANDLR = 12'h080,
    A_FVEC = 12'h104, A_MASK = 12'h110, A_EN = 12'h120, A_DIS = 12'h124;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0, fiq_src = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic fiq_req_n;

  int checks = 0, failures = 0;
  logic done = 1'b0;
  logic [DW-1:0] rv;

  always #10 clk = ~clk;

  fast_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .fiq_src(fiq_src), .fiq_req_n(fiq_req_n)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic src(logic v);
    @(negedge clk); fiq_src = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 req_n", fiq_req_n, 1);
    rd(A_MASK, rv);   chk("R1 mask", rv, 0);
    rd(A_SENSE, rv);  chk("R1 sense", rv, 0);
    rd(A_HANDLR, rv); chk("R1 handler", rv, 0);
  endtask

  task automatic t_vector;
    wr(A_HANDLR, 32'h1234_5678);
    rd(A_FVEC, rv);   chk("R8 fvec", rv, 32'h1234_5678);
    rd(A_HANDLR, rv); chk("R8 handler", rv, 32'h1234_5678);
    rd(A_SENSE, rv);  chk("R12 rdata updates", rv, 0);
  endtask

  task automatic t_rise;
    wr(A_SENSE, 0);
    wr(A_EN, 1);
    rd(A_MASK, rv); chk("R7 mask on", rv, 1);
    wr(A_DIS, 0);
    rd(A_MASK, rv); chk("R6 zero to disable ignored", rv, 1);
    chk("R13 idle", fiq_req_n, 1);
    src(1); chk("R2 rise latched", fiq_req_n, 0);
    rd(A_FVEC, rv);
    chk("R9 read clears", fiq_req_n, 1);
    chk("R8 fvec value", rv, 32'h1234_5678);
    src(0); chk("R2 fall ignored", fiq_req_n, 1);
  endtask

  task automatic t_fall;
    wr(A_SENSE, 1);
    src(1); chk("R3 rise ignored", fiq_req_n, 1);
    src(0); chk("R3 fall latched", fiq_req_n, 0);
    rd(A_FVEC, rv); chk("R9 fall cleared", fiq_req_n, 1);
  endtask

  task automatic t_high;
    wr(A_SENSE, 2);
    chk("R4 low input idle", fiq_req_n, 1);
    src(1); chk("R4 high asserts", fiq_req_n, 0);
    rd(A_FVEC, rv); chk("R4 read no clear", fiq_req_n, 0);
    src(0); chk("R4 released", fiq_req_n, 1);
  endtask

  task automatic t_low;
    src(1);
    wr(A_SENSE, 3);
    repeat (2) @(negedge clk);
    chk("R5 high input idle", fiq_req_n, 1);
    src(0); chk("R5 low asserts", fiq_req_n, 0);
    rd(A_FVEC, rv); chk("R5 read no clear", fiq_req_n, 0);
    src(1); chk("R5 released", fiq_req_n, 1);
  endtask

  task automatic t_mask;
    src(0);
    wr(A_SENSE, 0);
    repeat (2) @(negedge clk);
    src(1); chk("R10 latched", fiq_req_n, 0);
    wr(A_DIS, 0);   chk("R6 zero write no effect", fiq_req_n, 0);
    wr(A_DIS, 1);   chk("R10 masked", fiq_req_n, 1);
    rd(A_MASK, rv); chk("R7 mask off", rv, 0);
    repeat (3) @(negedge clk);
    wr(A_EN, 0);    chk("R6 zero enable ignored", fiq_req_n, 1);
    wr(A_EN, 1);    chk("R10 reasserted", fiq_req_n, 0);
    rd(A_FVEC, rv); chk("R9 cleared after re-enable", fiq_req_n, 1);
  endtask

  task automatic t_race;
    src(0);
    src(1); chk("R11 first edge latched", fiq_req_n, 0);
    src(0); chk("R11 still pending", fiq_req_n, 0);
    @(negedge clk); fiq_src = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_FVEC; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
    chk("R11 edge wins over clear", fiq_req_n, 0);
    chk("R11 vector returned", bus_rdata, 32'h1234_5678);
    rd(A_FVEC, rv); chk("R11 later read clears", fiq_req_n, 1);
  endtask

  task automatic t_unmapped;
    rd(A_FVEC, rv);
    rd(12'h3F0, rv); chk("R12 unmapped zero", rv, 0);
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", bus_rdata, 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_vector;
    t_rise;
    t_fall;
    t_high;
    t_low;
    t_mask;
    t_race;
    t_unmapped;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
    end
  end

endmodule